// File: doc/BRIEF.md
# USB PHY Line-State Wakeup Arming Controller

This block prepares a USB 2.0 PHY for low-power entry and restores it afterwards. On a power-down request it first puts the PHY analog section into retention. It then clears any stale line-state interrupts and arms the D+/D− transition detectors that suit the link's speed class. On a power-up request it disarms and clears those detectors, then takes the PHY out of retention. Each interrupt clear is a command toggle of 0 then 1 on a command register. Both halves of the toggle are followed by an enforced settling gap, measured with a microsecond tick.

The block drives a byte-wide register master port into the PHY register file. A read is a one-cycle strobe, and its data returns in the next cycle. Every change to the control, clear and mask registers is a read-modify-write, so bits outside the touched field keep their values. The link mode comes in on a small input and is sampled when a power-down request is accepted. Each request completes with a one-cycle done pulse on its own acknowledge line.

Top module: `lswake_ctrl`

## Requirements
- R1: During and right after the synchronous active-high reset, no read or write strobe and no done pulse is driven.
- R2: A power-down request produces these writes in order: retention register (address 0x10) with bit 2 set, clear register (0x1C) with bits 4..1 set, command register (0x14) with 0, command register with 1, and then the mask register (0x18) with the arm pattern ORed in. A single `pd_done` pulse follows the last write.
- R3: A power-up request produces these writes in order: mask register with bits 4..1 cleared, clear register with bits 4..1 set, command 0, command 1, and then the retention register with bit 2 cleared. A single `pu_done` pulse follows the last write.
- R4: At least GAP_US microsecond ticks pass between the command-0 write and the command-1 write. At least GAP_US ticks also pass between the command-1 write and the next register write.
- R5: Modes 1, 2, 4 and 5 (high or full speed, host or device) arm mask pattern 0x12: D+ falling (bit 4) and D− rising (bit 1).
- R6: Modes 3 and 6 (low speed, host or device) arm pattern 0x0C: D+ rising (bit 3) and D− falling (bit 2).
- R7: Mode 0 and mode 7 (nothing connected or unrecognised) arm pattern 0x0A: D+ rising (bit 3) and D− rising (bit 1).
- R8: Every register update reads the register with a one-cycle read strobe and writes back the read value with only its own field changed. Read and write strobes are never high in the same cycle.
- R9: The mode is sampled in the cycle the power-down request is accepted. A later change of `link_mode` does not alter the armed pattern.
- R10: Each done output is high for exactly one cycle. Requests that arrive while a sequence is running are ignored: they cause no extra writes and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| link_mode | input | 3 | Speed/role code of the link (0 none, 1/2 host HS/FS, 3 host LS, 4/5 device HS/FS, 6 device LS) |
| pd_req | input | 1 | Power-down request, sampled when idle |
| pd_done | output | 1 | One-cycle acknowledge of a power-down sequence |
| pu_req | input | 1 | Power-up request, sampled when idle |
| pu_done | output | 1 | One-cycle acknowledge of a power-up sequence |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_addr | output | AW | Register address |
| bus_wdata | output | 8 | Register write data |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |

## Verification
The hardest cases to reach from the ports are a request that arrives while a sequence is already running, and a mode change after a power-down has been accepted. Both have to land inside a window that only exists mid-sequence. The bench starts a power-down and waits a few hundred cycles, which puts it inside the first settling gap. It then pulses both request lines together and confirms that no write and no acknowledge follows the sequence's own. For the mode check, it switches `link_mode` to a different speed class one cycle after the request and expects the original class's arm pattern. The register model starts from non-zero background values, so a lost bit during read-modify-write shows up in the scoreboard.

// File: rtl/lswake_pkg.sv
package lswake_pkg;

  // Four line-transition enable bits, positions 4..1
  localparam logic [7:0] LINE_FIELD = 8'h1E;
  localparam logic [7:0] ARM_FAST   = 8'h12;  // D+ fall, D- rise
  localparam logic [7:0] ARM_LOW    = 8'h0C;  // D+ rise, D- fall
  localparam logic [7:0] ARM_IDLE   = 8'h0A;  // D+ rise, D- rise

  typedef enum logic [2:0] {
    K_OR   = 3'd0,
    K_ANDN = 3'd1,
    K_WR   = 3'd2,
    K_GAP  = 3'd3,
    K_END  = 3'd4
  } step_kind_e;

  function automatic logic [7:0] arm_pattern(input logic [2:0] mode);
    case (mode)
      3'd1, 3'd2, 3'd4, 3'd5: arm_pattern = ARM_FAST;
      3'd3, 3'd6:             arm_pattern = ARM_LOW;
      default:                arm_pattern = ARM_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/lswake_prog.sv
module lswake_prog
  import lswake_pkg::*;
#(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 'h10,
  parameter logic [AW-1:0] CMD_ADDR  = 'h14,
  parameter logic [AW-1:0] MASK_ADDR = 'h18,
  parameter logic [AW-1:0] CLR_ADDR  = 'h1C,
  parameter int            RET_BIT   = 2
) (
  input  logic          is_down,
  input  logic [7:0]    arm_bits,
  input  logic [2:0]    idx,
  output step_kind_e    kind,
  output logic [AW-1:0] addr,
  output logic [7:0]    val
);
  localparam logic [7:0] RET_M = 8'(1 << RET_BIT);

  always_comb begin
    kind = K_END;
    addr = '0;
    val  = '0;
    case (idx)
      3'd0: begin
        if (is_down) begin kind = K_OR;   addr = CTRL_ADDR; val = RET_M;      end
        else         begin kind = K_ANDN; addr = MASK_ADDR; val = LINE_FIELD; end
      end
      3'd1: begin kind = K_OR; addr = CLR_ADDR; val = LINE_FIELD; end
      3'd2: begin kind = K_WR; addr = CMD_ADDR; val = 8'h00;      end
      3'd3: kind = K_GAP;
      3'd4: begin kind = K_WR; addr = CMD_ADDR; val = 8'h01;      end
      3'd5: kind = K_GAP;
      3'd6: begin
        if (is_down) begin kind = K_OR;   addr = MASK_ADDR; val = arm_bits; end
        else         begin kind = K_ANDN; addr = CTRL_ADDR; val = RET_M;    end
      end
      default: kind = K_END;
    endcase
  end
endmodule

// File: rtl/lswake_gap.sv
module lswake_gap #(
  parameter int GAP_US = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(GAP_US + 1) + 1;

  logic [CW-1:0] cnt;
  logic          run;

  // Counts GAP_US+1 ticks so that at least GAP_US full microseconds elapse
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt <= CW'(GAP_US);
        run <= 1'b1;
      end else if (run && tick) begin
        if (cnt == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lswake_bus.sv
module lswake_bus
  import lswake_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  step_kind_e    kind,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    val,
  output logic          rd_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    wdata_o,
  input  logic [7:0]    rdata_i,
  output logic          done_o
);
  typedef enum logic [1:0] {B_IDLE, B_RD, B_CAP, B_WR} bus_st_e;

  bus_st_e    st;
  logic [7:0] op_val;
  logic       op_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= B_IDLE;
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      done_o  <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      op_val  <= '0;
      op_clr  <= 1'b0;
    end else begin
      rd_o   <= 1'b0;
      wr_o   <= 1'b0;
      done_o <= 1'b0;
      case (st)
        B_IDLE: if (start) begin
          addr_o <= addr;
          op_val <= val;
          op_clr <= (kind == K_ANDN);
          if (kind == K_WR) begin
            wr_o    <= 1'b1;
            wdata_o <= val;
            st      <= B_WR;
          end else begin
            rd_o <= 1'b1;
            st   <= B_RD;
          end
        end
        B_RD:  st <= B_CAP;
        B_CAP: begin
          wdata_o <= op_clr ? (rdata_i & ~op_val) : (rdata_i | op_val);
          wr_o    <= 1'b1;
          st      <= B_WR;
        end
        B_WR: begin
          done_o <= 1'b1;
          st     <= B_IDLE;
        end
        default: st <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lswake_ctrl.sv
module lswake_ctrl
  import lswake_pkg::*;
#(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 'h10,
  parameter logic [AW-1:0] CMD_ADDR  = 'h14,
  parameter logic [AW-1:0] MASK_ADDR = 'h18,
  parameter logic [AW-1:0] CLR_ADDR  = 'h1C,
  parameter int            RET_BIT   = 2,
  parameter int            GAP_US    = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          us_tick,
  input  logic [2:0]    link_mode,
  input  logic          pd_req,
  output logic          pd_done,
  input  logic          pu_req,
  output logic          pu_done,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_BUS, S_GAP} seq_st_e;

  seq_st_e       st;
  logic [2:0]    idx;
  logic          is_down;
  logic [7:0]    arm_q;
  logic          busy_w;

  step_kind_e    kind;
  logic [AW-1:0] step_addr;
  logic [7:0]    step_val;
  logic          bus_start, gap_start, bus_done, gap_done;

  assign busy_w    = (st != S_IDLE);
  assign bus_start = (st == S_ISSUE) && (kind == K_OR || kind == K_ANDN || kind == K_WR);
  assign gap_start = (st == S_ISSUE) && (kind == K_GAP);

  lswake_prog #(
    .AW(AW), .CTRL_ADDR(CTRL_ADDR), .CMD_ADDR(CMD_ADDR),
    .MASK_ADDR(MASK_ADDR), .CLR_ADDR(CLR_ADDR), .RET_BIT(RET_BIT)
  ) u_prog (
    .is_down (is_down),
    .arm_bits(arm_q),
    .idx     (idx),
    .kind    (kind),
    .addr    (step_addr),
    .val     (step_val)
  );

  lswake_bus #(.AW(AW)) u_bus (
    .clk    (clk),
    .rst    (rst),
    .start  (bus_start),
    .kind   (kind),
    .addr   (step_addr),
    .val    (step_val),
    .rd_o   (bus_rd),
    .wr_o   (bus_wr),
    .addr_o (bus_addr),
    .wdata_o(bus_wdata),
    .rdata_i(bus_rdata),
    .done_o (bus_done)
  );

  lswake_gap #(.GAP_US(GAP_US)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .start(gap_start),
    .tick (us_tick),
    .done (gap_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      idx     <= '0;
      is_down <= 1'b0;
      arm_q   <= ARM_IDLE;
      pd_done <= 1'b0;
      pu_done <= 1'b0;
    end else begin
      pd_done <= 1'b0;
      pu_done <= 1'b0;
      case (st)
        S_IDLE: begin
          idx <= '0;
          if (pd_req) begin
            is_down <= 1'b1;
            arm_q   <= arm_pattern(link_mode);
            st      <= S_ISSUE;
          end else if (pu_req) begin
            is_down <= 1'b0;
            st      <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (kind == K_END) begin
            pd_done <= is_down;
            pu_done <= !is_down;
            st      <= S_IDLE;
          end else if (kind == K_GAP) begin
            st <= S_GAP;
          end else begin
            st <= S_BUS;
          end
        end
        S_BUS: if (bus_done) begin
          idx <= idx + 1'b1;
          st  <= S_ISSUE;
        end
        S_GAP: if (gap_done) begin
          idx <= idx + 1'b1;
          st  <= S_ISSUE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lswake_chk.sv
module lswake_chk #(
  parameter int            AW       = 8,
  parameter logic [AW-1:0] CMD_ADDR = 'h14,
  parameter int            GAP_US   = 200
) (
  input logic          clk,
  input logic          rst,
  input logic          us_tick,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          pd_done,
  input logic          pu_done,
  input logic          busy
);
  localparam int CW = $clog2(GAP_US + 2);

  logic [CW-1:0] tk_cnt;

  always_ff @(posedge clk) begin
    if (rst) tk_cnt <= '0;
    else if (bus_wr && bus_addr == CMD_ADDR) tk_cnt <= '0;
    else if (us_tick && tk_cnt != CW'(GAP_US + 1)) tk_cnt <= tk_cnt + 1'b1;
  end

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!bus_rd && !bus_wr && !pd_done && !pu_done));

  // R8
  no_rdwr_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R10
  pd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pd_done |=> !pd_done);

  // R10
  pu_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pu_done |=> !pu_done);

  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pd_done && pu_done));

  // R2
  bus_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> busy);

  // R4
  cmd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == CMD_ADDR && bus_wdata == 8'h01) |-> (tk_cnt >= CW'(GAP_US)));

endmodule

bind lswake_ctrl lswake_chk #(
  .AW(AW), .CMD_ADDR(CMD_ADDR), .GAP_US(GAP_US)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .us_tick  (us_tick),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .pd_done  (pd_done),
  .pu_done  (pu_done),
  .busy     (busy_w)
);

// File: tb/lswake_ctrl_tb.sv
`timescale 1ns/1ps
module lswake_ctrl_tb;
  localparam int         AW       = 8;
  localparam logic [7:0] A_CTRL   = 8'h10;
  localparam logic [7:0] A_CMD    = 8'h14;
  localparam logic [7:0] A_MASK   = 8'h18;
  localparam logic [7:0] A_CLR    = 8'h1C;
  localparam int         GAP      = 200;
  localparam int         TICK_DIV = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          us_tick = 1'b0;
  logic [2:0]    link_mode = 3'd0;
  logic          pd_req = 1'b0, pu_req = 1'b0;
  logic          pd_done, pu_done, bus_rd, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata = 8'h00;

  lswake_ctrl u_dut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .link_mode(link_mode),
    .pd_req(pd_req), .pd_done(pd_done), .pu_req(pu_req), .pu_done(pu_done),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Register file model: read data one cycle after the strobe
  logic [7:0] regs [0:255];
  always @(posedge clk) begin
    if (bus_rd) bus_rdata <= regs[bus_addr];
    if (bus_wr) regs[bus_addr] <= bus_wdata;
  end

  int div = 0;
  always @(negedge clk) begin
    if (div == TICK_DIV - 1) begin div = 0; us_tick <= 1'b1; end
    else begin div++; us_tick <= 1'b0; end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  m_ctrl, m_clr, m_mask;

  task automatic push(input logic [7:0] a, input logic [7:0] d, input string t);
    exp_q.push_back({a, d});
    tag_q.push_back(t);
  endtask

  int tk = 0;
  bit after1 = 0;
  int wr_total = 0, pd_seen = 0, pu_seen = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_wr) begin
        logic [15:0] e;
        string t;
        wr_total++;
        chk(!bus_rd, "R8", "read and write together", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected write", {bus_addr, bus_wdata}, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({bus_addr, bus_wdata} == e, t, "write addr/data", {bus_addr, bus_wdata}, e);
        end
        if (after1) chk(tk >= GAP, "R4", "ticks after command 1", tk, GAP);
        if (bus_addr == A_CMD && bus_wdata == 8'h01)
          chk(tk >= GAP, "R4", "ticks between command 0 and 1", tk, GAP);
        after1 = (bus_addr == A_CMD && bus_wdata == 8'h01);
        if (bus_addr == A_CMD) tk = 0;
      end
      if (us_tick) tk++;
      if (pd_done) pd_seen++;
      if (pu_done) pu_seen++;
    end
  end

  function automatic logic [7:0] arm_of(input logic [2:0] m);
    case (m)
      3'd1, 3'd2, 3'd4, 3'd5: arm_of = 8'h12;  // R5
      3'd3, 3'd6:             arm_of = 8'h0C;  // R6
      default:                arm_of = 8'h0A;  // R7
    endcase
  endfunction

  task automatic push_down(input logic [2:0] m, input string rsel);
    push(A_CTRL, m_ctrl | 8'h04, "R2/R8"); m_ctrl = m_ctrl | 8'h04;
    push(A_CLR,  m_clr  | 8'h1E, "R2/R8"); m_clr  = m_clr  | 8'h1E;
    push(A_CMD,  8'h00, "R2");
    push(A_CMD,  8'h01, "R2");
    push(A_MASK, m_mask | arm_of(m), rsel); m_mask = m_mask | arm_of(m);
  endtask

  task automatic wait_done(input bit down, input string req);
    int n = 0;
    while (!(down ? pd_done : pu_done) && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(n < 20000, req, "done pulse seen", n, 0);
    chk(exp_q.size() == 0, req, "writes outstanding at done", exp_q.size(), 0);
    @(negedge clk);
    chk(!(down ? pd_done : pu_done), "R10", "done lasts one cycle", 1, 0);
  endtask

  task automatic run_down(input logic [2:0] m, input logic [2:0] m_after, input string rsel);
    push_down(m, rsel);
    @(negedge clk);
    link_mode = m; pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0; link_mode = m_after;
    wait_done(1'b1, "R2");
  endtask

  task automatic run_up();
    push(A_MASK, m_mask & ~8'h1E, "R3/R8"); m_mask = m_mask & ~8'h1E;
    push(A_CLR,  m_clr | 8'h1E,   "R3/R8"); m_clr  = m_clr | 8'h1E;
    push(A_CMD,  8'h00, "R3");
    push(A_CMD,  8'h01, "R3");
    push(A_CTRL, m_ctrl & ~8'h04, "R3/R8"); m_ctrl = m_ctrl & ~8'h04;
    @(negedge clk);
    pu_req = 1'b1;
    @(negedge clk);
    pu_req = 1'b0;
    wait_done(1'b0, "R3");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) regs[i] = 8'h00;
    regs[A_CTRL] = 8'hA1; regs[A_CLR] = 8'h40; regs[A_MASK] = 8'h81;
    m_ctrl = 8'hA1; m_clr = 8'h40; m_mask = 8'h81;
    repeat (4) @(negedge clk);
    chk(!bus_rd && !bus_wr && !pd_done && !pu_done, "R1", "quiet in reset", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_rd && !bus_wr && !pd_done && !pu_done, "R1", "quiet after reset", 0, 0);

    run_down(3'd1, 3'd1, "R5"); run_up();
    run_down(3'd5, 3'd5, "R5"); run_up();
    run_down(3'd3, 3'd1, "R6/R9"); run_up();
    run_down(3'd6, 3'd6, "R6"); run_up();
    run_down(3'd0, 3'd0, "R7"); run_up();
    run_down(3'd7, 3'd7, "R7"); run_up();

    // R10: requests during a running sequence are dropped
    begin
      int pu0, pd0, w0;
      push_down(3'd2, "R5");
      @(negedge clk);
      link_mode = 3'd2; pd_req = 1'b1;
      @(negedge clk);
      pd_req = 1'b0;
      pd0 = pd_seen;
      repeat (300) @(negedge clk);
      pd_req = 1'b1; pu_req = 1'b1;
      @(negedge clk);
      pd_req = 1'b0; pu_req = 1'b0;
      pu0 = pu_seen;
      wait_done(1'b1, "R10");
      w0 = wr_total;
      repeat (60) @(negedge clk);
      chk(pu_seen == pu0, "R10", "no power-up ack from dropped request", pu_seen, pu0);
      chk(pd_seen == pd0 + 1, "R10", "one power-down ack", pd_seen, pd0 + 1);
      chk(wr_total == w0, "R10", "no writes after done", wr_total, w0);
    end
    run_up();

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
      summary();
      $finish;
    end
  end
endmodule